// File: doc/BRIEF.md
# Two-Descriptor Transmit Packet Assembler

This block takes 128-bit transmit descriptors one at a time from a descriptor cache. It turns each one into a DMA read of that descriptor's buffer. A packet may be described by a single descriptor, or by a header descriptor followed by a data descriptor. For the split case, the length of the header buffer is held so that the data buffer lands right behind it in the packet buffer. The DMA reader writes the bytes; this block only supplies the destination offset.

Before a request goes out, the block reserves room in the downstream transmit FIFO. When the reader signals that the data has arrived, the block returns the descriptor with its done field set. If that descriptor ends the packet, the block also reports the total packet length.

Descriptors that ask for VLAN tag insertion are refused with an error pulse. So is a second header descriptor arriving while one is already held.

Top module: `txasm_top`

## Requirements
- R1: After a synchronous active-high reset, `desc_ready` is 1, the pulse outputs `fifo_rsv_valid`, `dma_req_valid`, `wb_valid`, `pkt_valid` and `desc_err` are 0, and no header length is held: the first descriptor of a packet gets destination offset 0.
- R2: The buffer length comes from the upper 64-bit word (`desc_in[127:64]`). If bit 29 of that word is 0 (legacy format), the length is bits 15:0. If bit 29 is 1 (extended data format), the length is bits 19:0. The buffer address is the lower word, `desc_in[63:0]`.
- R3: In the upper word, bit 24 marks end of packet and bit 30 requests VLAN insertion. Bits 25, 26 and 27 (insert FCS, segmentation/checksum, report status) have no effect on the block and are returned unchanged.
- R4: A reservation pulse (`fifo_rsv_valid`, with `fifo_rsv_len` equal to the buffer length) is issued only in a cycle where `fifo_free` is strictly greater than the buffer length. Otherwise the block waits.
- R5: The DMA request pulse follows its reservation by exactly one cycle. It carries the buffer address, the buffer length and the destination offset, where the offset equals the held header length.
- R6: One cycle after `dma_done`, `wb_valid` pulses. `wb_desc` equals the accepted descriptor with upper-word bits 35:32 (`wb_desc[99:96]`) set to 4'h1 and every other bit unchanged.
- R7: When a descriptor without end of packet completes, its length becomes the held header length and no packet is reported.
- R8: When an end-of-packet descriptor completes, `pkt_len` equals its length plus the held header length. The held header length then returns to 0.
- R9: `pkt_valid` is raised only for a nonzero total. A descriptor with a zero length issues no reservation or DMA request, and is written back in the cycle after it is accepted.
- R10: A descriptor with VLAN insertion set pulses `desc_err` in the cycle after acceptance. It produces no reservation, no request and no writeback, and leaves the held header length untouched.
- R11: A descriptor without end of packet that arrives while a header length is held pulses `desc_err` and is dropped. The held header length is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Block idle, takes the offered descriptor |
| desc_in | input | 128 | Descriptor (lower word address, upper word length and command) |
| fifo_free | input | FREE_W | Free bytes in downstream FIFO |
| fifo_rsv_valid | output | 1 | Reservation pulse |
| fifo_rsv_len | output | LEN_W | Bytes reserved |
| dma_req_valid | output | 1 | DMA read request pulse |
| dma_addr | output | 64 | Source buffer address |
| dma_len | output | LEN_W | Bytes to read |
| dma_off | output | LEN_W | Destination byte offset in packet buffer |
| dma_done | input | 1 | DMA data complete |
| wb_valid | output | 1 | Descriptor writeback pulse |
| wb_desc | output | 128 | Descriptor with done field set |
| pkt_valid | output | 1 | Packet complete pulse |
| pkt_len | output | LEN_W+1 | Total packet length |
| desc_err | output | 1 | Descriptor refused |

## Verification
All outputs are registered.

For an accepted descriptor, the timing is as follows. The error pulse, or the writeback of a zero-length descriptor, appears one edge after acceptance. The reservation appears two edges after acceptance if space is already free, and the DMA request one edge after the reservation. The writeback and packet report appear one edge after `dma_done`.

Each scenario task drives inputs at the falling edge and counts edges from acceptance. It checks every pulse at the falling edge in which it is due, and also confirms that the pulse is absent in the cycles before and after.

// File: rtl/txasm_pkg.sv
package txasm_pkg;
  localparam int DESC_W   = 128;
  localparam int UP_BASE  = 64;
  localparam int LEG_LEN_W = 16;
  localparam int EXT_LEN_W = 20;
  localparam int B_EOP    = UP_BASE + 24;
  localparam int B_EXT    = UP_BASE + 29;
  localparam int B_VLAN   = UP_BASE + 30;
  localparam int B_DONE_LO = UP_BASE + 32;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SPACE = 2'd1,
    ST_ISSUE = 2'd2,
    ST_WAIT  = 2'd3
  } asm_state_t;

  function automatic logic [DESC_W-1:0] mark_done(input logic [DESC_W-1:0] d);
    logic [DESC_W-1:0] r;
    r = d;
    r[B_DONE_LO +: 4] = 4'h1;
    return r;
  endfunction
endpackage

// File: rtl/txasm_field_decode.sv
module txasm_field_decode
  import txasm_pkg::*;
#(
  parameter int LEN_W = 20
) (
  input  logic [DESC_W-1:0] desc,
  output logic [LEN_W-1:0]  buf_len,
  output logic [63:0]       buf_addr,
  output logic              is_eop,
  output logic              is_vlan
);
  logic ext_fmt;
  assign ext_fmt  = desc[B_EXT];
  assign is_eop   = desc[B_EOP];
  assign is_vlan  = desc[B_VLAN];
  assign buf_addr = desc[63:0];

  always_comb begin
    buf_len = '0;
    if (ext_fmt) buf_len = LEN_W'(desc[UP_BASE +: EXT_LEN_W]);
    else         buf_len = LEN_W'(desc[UP_BASE +: LEG_LEN_W]);
  end
endmodule

// File: rtl/txasm_hdr_track.sv
module txasm_hdr_track #(
  parameter int LEN_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             save,
  input  logic [LEN_W-1:0] save_len,
  input  logic             clear,
  output logic [LEN_W-1:0] hdr_len,
  output logic             hdr_busy
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hdr_len  <= '0;
      hdr_busy <= 1'b0;
    end else if (save) begin
      hdr_len  <= save_len;
      hdr_busy <= 1'b1;
    end else if (clear) begin
      hdr_len  <= '0;
      hdr_busy <= 1'b0;
    end
  end

  AST_SINGLE_HDR: assert property (@(posedge clk) disable iff (rst)
    save |-> !hdr_busy); // R11
  AST_SAVE_CLEAR_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(save && clear)); // R8
endmodule

// File: rtl/txasm_ctrl.sv
module txasm_ctrl
  import txasm_pkg::*;
#(
  parameter int LEN_W  = 20,
  parameter int FREE_W = 21
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              desc_valid,
  output logic              desc_ready,
  input  logic [DESC_W-1:0] desc_in,
  input  logic [LEN_W-1:0]  dec_len,
  input  logic [63:0]       dec_addr,
  input  logic              dec_eop,
  input  logic              dec_vlan,
  input  logic [LEN_W-1:0]  hdr_len,
  input  logic              hdr_busy,
  output logic              hdr_save,
  output logic [LEN_W-1:0]  hdr_save_len,
  output logic              hdr_clear,
  input  logic [FREE_W-1:0] fifo_free,
  output logic              fifo_rsv_valid,
  output logic [LEN_W-1:0]  fifo_rsv_len,
  output logic              dma_req_valid,
  output logic [63:0]       dma_addr,
  output logic [LEN_W-1:0]  dma_len,
  output logic [LEN_W-1:0]  dma_off,
  input  logic              dma_done,
  output logic              wb_valid,
  output logic [DESC_W-1:0] wb_desc,
  output logic              pkt_valid,
  output logic [LEN_W:0]    pkt_len,
  output logic              desc_err
);
  localparam int CMP_W = (FREE_W > LEN_W) ? FREE_W : LEN_W;

  asm_state_t        state;
  logic [DESC_W-1:0] cur_desc;
  logic [LEN_W-1:0]  cur_len;
  logic [63:0]       cur_addr;
  logic              cur_eop;

  logic              accept, refuse, zero_len, finish_now, fin_eop, room_ok;
  logic [LEN_W-1:0]  fin_len;
  logic [LEN_W:0]    total;

  assign desc_ready = (state == ST_IDLE);
  assign accept     = desc_ready && desc_valid;
  assign refuse     = dec_vlan || (!dec_eop && hdr_busy);
  assign zero_len   = (dec_len == '0);
  assign room_ok    = CMP_W'(fifo_free) > CMP_W'(cur_len);

  always_comb begin
    finish_now = 1'b0;
    fin_eop    = cur_eop;
    fin_len    = cur_len;
    if (state == ST_IDLE) begin
      finish_now = accept && !refuse && zero_len;
      fin_eop    = dec_eop;
      fin_len    = dec_len;
    end else if (state == ST_WAIT) begin
      finish_now = dma_done;
    end
  end

  assign total        = {1'b0, fin_len} + {1'b0, hdr_len};
  assign hdr_save     = finish_now && !fin_eop;
  assign hdr_save_len = fin_len;
  assign hdr_clear    = finish_now && fin_eop;

  always_ff @(posedge clk) begin
    if (rst) begin
      state          <= ST_IDLE;
      cur_desc       <= '0;
      cur_len        <= '0;
      cur_addr       <= '0;
      cur_eop        <= 1'b0;
      fifo_rsv_valid <= 1'b0;
      fifo_rsv_len   <= '0;
      dma_req_valid  <= 1'b0;
      dma_addr       <= '0;
      dma_len        <= '0;
      dma_off        <= '0;
      wb_valid       <= 1'b0;
      wb_desc        <= '0;
      pkt_valid      <= 1'b0;
      pkt_len        <= '0;
      desc_err       <= 1'b0;
    end else begin
      fifo_rsv_valid <= 1'b0;
      dma_req_valid  <= 1'b0;
      wb_valid       <= 1'b0;
      pkt_valid      <= 1'b0;
      desc_err       <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            if (refuse) begin
              desc_err <= 1'b1;
            end else begin
              cur_desc <= desc_in;
              cur_len  <= dec_len;
              cur_addr <= dec_addr;
              cur_eop  <= dec_eop;
              if (!zero_len) state <= ST_SPACE;
            end
          end
        end
        ST_SPACE: begin
          if (room_ok) begin
            fifo_rsv_valid <= 1'b1;
            fifo_rsv_len   <= cur_len;
            state          <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          dma_req_valid <= 1'b1;
          dma_addr      <= cur_addr;
          dma_len       <= cur_len;
          dma_off       <= hdr_len;
          state         <= ST_WAIT;
        end
        default: begin
          if (dma_done) state <= ST_IDLE;
        end
      endcase
      if (finish_now) begin
        wb_valid <= 1'b1;
        wb_desc  <= mark_done((state == ST_IDLE) ? desc_in : cur_desc);
        if (fin_eop) begin
          pkt_len   <= total;
          pkt_valid <= (total != '0);
        end
      end
    end
  end

  AST_RSV_HAS_ROOM: assert property (@(posedge clk) disable iff (rst)
    fifo_rsv_valid |-> (CMP_W'($past(fifo_free)) > CMP_W'($past(cur_len)))); // R4
  AST_REQ_AFTER_RSV: assert property (@(posedge clk) disable iff (rst)
    dma_req_valid |-> $past(fifo_rsv_valid)); // R5
  AST_REQ_LEN_MATCH: assert property (@(posedge clk) disable iff (rst)
    dma_req_valid |-> (dma_len == $past(fifo_rsv_len))); // R5
  AST_WB_DONE_FIELD: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> (wb_desc[B_DONE_LO +: 4] == 4'h1)); // R6
  AST_PKT_NONZERO: assert property (@(posedge clk) disable iff (rst)
    pkt_valid |-> (pkt_len != '0)); // R9
  AST_ERR_ALONE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({desc_err, wb_valid, fifo_rsv_valid, dma_req_valid})); // R10
endmodule

// File: rtl/txasm_top.sv
module txasm_top
  import txasm_pkg::*;
#(
  parameter int LEN_W  = 20,
  parameter int FREE_W = 21
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              desc_valid,
  output logic              desc_ready,
  input  logic [127:0]      desc_in,
  input  logic [FREE_W-1:0] fifo_free,
  output logic              fifo_rsv_valid,
  output logic [LEN_W-1:0]  fifo_rsv_len,
  output logic              dma_req_valid,
  output logic [63:0]       dma_addr,
  output logic [LEN_W-1:0]  dma_len,
  output logic [LEN_W-1:0]  dma_off,
  input  logic              dma_done,
  output logic              wb_valid,
  output logic [127:0]      wb_desc,
  output logic              pkt_valid,
  output logic [LEN_W:0]    pkt_len,
  output logic              desc_err
);
  logic [LEN_W-1:0] dec_len, hdr_len, hdr_save_len;
  logic [63:0]      dec_addr;
  logic             dec_eop, dec_vlan, hdr_busy, hdr_save, hdr_clear;

  txasm_field_decode #(.LEN_W(LEN_W)) u_dec (
    .desc(desc_in), .buf_len(dec_len), .buf_addr(dec_addr),
    .is_eop(dec_eop), .is_vlan(dec_vlan)
  );

  txasm_hdr_track #(.LEN_W(LEN_W)) u_hdr (
    .clk(clk), .rst(rst), .save(hdr_save), .save_len(hdr_save_len),
    .clear(hdr_clear), .hdr_len(hdr_len), .hdr_busy(hdr_busy)
  );

  txasm_ctrl #(.LEN_W(LEN_W), .FREE_W(FREE_W)) u_ctrl (
    .clk(clk), .rst(rst), .desc_valid(desc_valid), .desc_ready(desc_ready),
    .desc_in(desc_in), .dec_len(dec_len), .dec_addr(dec_addr),
    .dec_eop(dec_eop), .dec_vlan(dec_vlan), .hdr_len(hdr_len),
    .hdr_busy(hdr_busy), .hdr_save(hdr_save), .hdr_save_len(hdr_save_len),
    .hdr_clear(hdr_clear), .fifo_free(fifo_free),
    .fifo_rsv_valid(fifo_rsv_valid), .fifo_rsv_len(fifo_rsv_len),
    .dma_req_valid(dma_req_valid), .dma_addr(dma_addr), .dma_len(dma_len),
    .dma_off(dma_off), .dma_done(dma_done), .wb_valid(wb_valid),
    .wb_desc(wb_desc), .pkt_valid(pkt_valid), .pkt_len(pkt_len),
    .desc_err(desc_err)
  );

  AST_OFF_ZERO_IDLE_HDR: assert property (@(posedge clk) disable iff (rst)
    (dma_req_valid && !$past(hdr_busy)) |-> (dma_off == '0)); // R1
endmodule

// File: tb/txasm_top_tb.sv
`timescale 1ns/100ps
module txasm_top_tb;
  localparam int LEN_W  = 20;
  localparam int FREE_W = 21;

  logic              clk = 1'b0;
  logic              rst, desc_valid, dma_done;
  logic [127:0]      desc_in;
  logic [FREE_W-1:0] fifo_free;
  logic              desc_ready, fifo_rsv_valid, dma_req_valid, wb_valid, pkt_valid, desc_err;
  logic [LEN_W-1:0]  fifo_rsv_len, dma_len, dma_off;
  logic [63:0]       dma_addr;
  logic [127:0]      wb_desc;
  logic [LEN_W:0]    pkt_len;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  txasm_top #(.LEN_W(LEN_W), .FREE_W(FREE_W)) u_dut (
    .clk(clk), .rst(rst), .desc_valid(desc_valid), .desc_ready(desc_ready),
    .desc_in(desc_in), .fifo_free(fifo_free), .fifo_rsv_valid(fifo_rsv_valid),
    .fifo_rsv_len(fifo_rsv_len), .dma_req_valid(dma_req_valid),
    .dma_addr(dma_addr), .dma_len(dma_len), .dma_off(dma_off),
    .dma_done(dma_done), .wb_valid(wb_valid), .wb_desc(wb_desc),
    .pkt_valid(pkt_valid), .pkt_len(pkt_len), .desc_err(desc_err)
  );

  task automatic chk(input bit ok, input string req, input logic [127:0] got,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [127:0] mk(input logic [63:0] addr, input logic [19:0] len,
                                      input bit ext, input bit eop, input bit vlan);
    logic [63:0] up;
    up = 64'h0;
    up[19:0] = len;
    up[25] = 1'b1;
    up[27] = 1'b1;
    up[29] = ext;
    up[24] = eop;
    up[30] = vlan;
    up[63:48] = 16'hA5C3;
    return {up, addr};
  endfunction

  function automatic logic [127:0] done_of(input logic [127:0] d);
    logic [127:0] r;
    r = d;
    r[99:96] = 4'h1;
    return r;
  endfunction

  task automatic send(input logic [127:0] d);
    @(negedge clk);
    desc_in = d;
    desc_valid = 1'b1;
    @(posedge clk);
    #1 desc_valid = 1'b0;
  endtask

  task automatic run_desc(input string req, input logic [127:0] d,
                          input logic [19:0] elen, input logic [19:0] eoff,
                          input bit epkt, input logic [20:0] eplen);
    send(d);
    @(negedge clk);
    chk(!fifo_rsv_valid && !dma_req_valid, req, {fifo_rsv_valid, dma_req_valid}, 0);
    @(negedge clk);
    chk(fifo_rsv_valid && fifo_rsv_len == elen && !dma_req_valid, {req, " R4 rsv"},
        {fifo_rsv_valid, fifo_rsv_len}, {1'b1, elen});
    @(negedge clk);
    chk(dma_req_valid && !fifo_rsv_valid, {req, " R5 req"}, dma_req_valid, 1);
    chk(dma_addr == d[63:0] && dma_len == elen && dma_off == eoff, {req, " R5 fields"},
        {dma_addr, dma_len, dma_off}, {d[63:0], elen, eoff});
    dma_done = 1'b1;
    @(negedge clk);
    dma_done = 1'b0;
    chk(wb_valid && wb_desc == done_of(d), {req, " R6 wb"}, wb_desc, done_of(d));
    chk(pkt_valid == epkt && (!epkt || pkt_len == eplen), {req, " R7/R8 pkt"},
        {pkt_valid, pkt_len}, {epkt, eplen});
    @(negedge clk);
    chk(!wb_valid && !pkt_valid && desc_ready, {req, " pulses end"},
        {wb_valid, pkt_valid, desc_ready}, 3'b001);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(desc_ready && !fifo_rsv_valid && !dma_req_valid && !wb_valid && !pkt_valid && !desc_err,
        "R1 reset", {desc_ready, fifo_rsv_valid, dma_req_valid, wb_valid, pkt_valid, desc_err},
        6'b100000);
  endtask

  task automatic t_single_legacy();
    run_desc("R2 R3 legacy eop", mk(64'h0000_1000_2000_3000, 20'd100, 0, 1, 0),
             20'd100, 20'd0, 1, 21'd100);
  endtask

  task automatic t_len_formats();
    run_desc("R2 legacy ignores 19:16", mk(64'h44, 20'hF0040, 0, 1, 0),
             20'h00040, 20'd0, 1, 21'h40);
    run_desc("R2 extended 19:0", mk(64'h88, 20'h10040, 1, 1, 0),
             20'h10040, 20'd0, 1, 21'h10040);
  endtask

  task automatic t_split();
    run_desc("R7 header", mk(64'h500, 20'd14, 0, 0, 0), 20'd14, 20'd0, 0, 21'd0);
    run_desc("R8 data after header", mk(64'h900, 20'd50, 1, 1, 0), 20'd50, 20'd14, 1, 21'd64);
    run_desc("R8 header cleared", mk(64'hA00, 20'd8, 0, 1, 0), 20'd8, 20'd0, 1, 21'd8);
  endtask

  task automatic t_vlan();
    send(mk(64'h123, 20'd30, 0, 1, 1));
    @(negedge clk);
    chk(desc_err && !wb_valid && !fifo_rsv_valid, "R10 vlan error", {desc_err, wb_valid}, 2'b10);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!fifo_rsv_valid && !dma_req_valid && !wb_valid && !desc_err && desc_ready,
          "R10 no activity", {fifo_rsv_valid, dma_req_valid, wb_valid, desc_ready}, 4'b0001);
    end
  endtask

  task automatic t_second_header();
    run_desc("R7 first header", mk(64'h600, 20'd20, 0, 0, 0), 20'd20, 20'd0, 0, 21'd0);
    send(mk(64'h700, 20'd9, 0, 0, 0));
    @(negedge clk);
    chk(desc_err && !wb_valid, "R11 second header refused", {desc_err, wb_valid}, 2'b10);
    send(mk(64'h777, 20'd5, 0, 1, 1));
    @(negedge clk);
    chk(desc_err, "R10 vlan keeps header", desc_err, 1);
    run_desc("R11 header kept", mk(64'h800, 20'd10, 0, 1, 0), 20'd10, 20'd20, 1, 21'd30);
  endtask

  task automatic t_space();
    logic [127:0] d;
    d = mk(64'hBEEF, 20'd40, 0, 1, 0);
    fifo_free = 21'd40;
    send(d);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!fifo_rsv_valid && !dma_req_valid, "R4 stall when free == len",
          {fifo_rsv_valid, dma_req_valid}, 0);
    end
    fifo_free = 21'd41;
    @(negedge clk);
    chk(fifo_rsv_valid && fifo_rsv_len == 20'd40, "R4 reserve when free > len",
        {fifo_rsv_valid, fifo_rsv_len}, {1'b1, 20'd40});
    fifo_free = 21'h1FFFFF;
    @(negedge clk);
    chk(dma_req_valid && dma_len == 20'd40, "R5 request after reserve", dma_req_valid, 1);
    dma_done = 1'b1;
    @(negedge clk);
    dma_done = 1'b0;
    chk(wb_valid && pkt_valid && pkt_len == 21'd40, "R8 pkt after stall", pkt_len, 40);
  endtask

  task automatic t_zero_len();
    logic [127:0] d;
    d = mk(64'hCAFE, 20'd0, 0, 1, 0);
    send(d);
    @(negedge clk);
    chk(wb_valid && wb_desc == done_of(d), "R9 zero length written back", wb_desc, done_of(d));
    chk(!pkt_valid && !fifo_rsv_valid, "R9 zero length no pkt", {pkt_valid, fifo_rsv_valid}, 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!fifo_rsv_valid && !dma_req_valid && desc_ready, "R9 no request",
          {fifo_rsv_valid, dma_req_valid, desc_ready}, 3'b001);
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1;
    desc_valid = 1'b0;
    dma_done = 1'b0;
    desc_in = '0;
    fifo_free = 21'h1FFFFF;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_single_legacy();
    t_len_formats();
    t_split();
    t_vlan();
    t_second_header();
    t_space();
    t_zero_len();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule